// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block works alongside a small processor core and carries out the hardware half of taking an interrupt and coming back from it. Device request lines and a software trap request are captured into a pending set. When the core signals that an instruction has just finished, the sequencer takes the highest-priority pending source. It records the return program counter and the current privilege mode, switches the core to monitor mode and reads the service-routine pointer for that source from a pointer table in low memory.

The table read uses a valid/ready request channel and a separate response strobe. Once the pointer arrives, the sequencer issues a single-cycle redirect to it and stays in service until the core reports a return-from-interrupt. At that point it redirects to the saved counter and puts back the saved mode. Only one level of service is supported. Requests that arrive meanwhile stay pending. General register saving is left to software.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, priv_mode is 0 (monitor), and vec_valid, redirect_valid and in_service are all 0.
- R2: A pending request is taken only in a cycle where insn_done is 1 and no interrupt is in service. Without that strobe, vec_valid stays 0 however long a request has been pending.
- R3: The source taken is chosen by fixed priority. The software trap beats every device, and among devices the lowest index wins. grant_id reports the choice, with devices as 0..NUM_DEV-1 and the trap as NUM_DEV.
- R4: The pointer read address is VEC_BASE + grant_id * PTR_BYTES, which is grant_id*4 with the defaults (base 0, 4-byte pointers).
- R5: vec_valid stays high with a stable vec_addr until vec_ready is seen. redirect_valid rises only in the cycle after vec_rsp_valid, lasts exactly one cycle, and carries vec_rsp_data on redirect_pc.
- R6: On entry, ret_pc and the current mode are saved, and priv_mode reads 0 from the first cycle of the pointer read.
- R7: rti_strobe during service gives a one-cycle redirect to the saved ret_pc in the next cycle, restores the saved mode on priv_mode, and clears in_service.
- R8: Requests that arrive while an interrupt is in service are held and are not taken, even with insn_done high, until after the return.
- R9: rti_strobe outside service has no effect: no redirect, and priv_mode is unchanged.
- R10: enter_user sets priv_mode to 1 (user) in the next cycle, unless an entry is taken in the same cycle.
- R11: Each pending request is cleared only by its own grant. A request and a grant of the same source in the same cycle leave it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NUM_DEV | Device request pulses, one bit per device |
| trap_req | input | 1 | Software trap request pulse |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| ret_pc | input | ADDR_W | Return address offered by the core at the boundary |
| rti_strobe | input | 1 | Return-from-interrupt strobe |
| enter_user | input | 1 | Switch to user mode |
| vec_valid | output | 1 | Pointer read request valid |
| vec_addr | output | ADDR_W | Pointer read address |
| vec_ready | input | 1 | Memory accepts the pointer read |
| vec_rsp_valid | input | 1 | Pointer read data valid |
| vec_rsp_data | input | ADDR_W | Pointer read data |
| redirect_valid | output | 1 | One-cycle redirect pulse to the core |
| redirect_pc | output | ADDR_W | Redirect target |
| grant_id | output | ID_W | Source number of the interrupt taken |
| priv_mode | output | 1 | Mode bit: 0 monitor, 1 user |
| in_service | output | 1 | An entry or service is in progress |

## Verification
The hardest state to reach from the ports is a set of requests that pile up from several earlier rounds and then meet the priority logic together, since each entry removes only one source. The bench keeps its own model of the pending set across a table of entry/return rounds. Rows add new requests on top of the ones left over, so trap-over-device and lowest-index ordering get checked against sets the rows did not provide in a single step. A directed case holds the boundary strobe high all through a service period to show that queued requests wait for the return. Another leaves a request pending with no boundary strobe to show that the strobe is required.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_SERVE = 2'd3
    } seq_state_e;

    localparam logic MODE_MONITOR = 1'b0;
    localparam logic MODE_USER    = 1'b1;

    // byte offset of a pointer slot inside the table
    function automatic int unsigned slot_offset(input int unsigned id, input int unsigned bytes);
        return id * bytes;
    endfunction

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
    parameter int NUM_DEV = 8,
    parameter int ID_W    = $clog2(NUM_DEV + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DEV-1:0] dev_req,
    input  logic               trap_req,
    input  logic               take,
    output logic               any_pend,
    output logic [ID_W-1:0]    pick_id
);
    localparam int NUM_SRC = NUM_DEV + 1;

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] clr_v;

    assign set_v    = {trap_req, dev_req};
    assign any_pend = |pend_q;

    // trap first, then the lowest device index
    always_comb begin
        pick_id = '0;
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (pend_q[i]) pick_id = ID_W'(i);
        end
        if (pend_q[NUM_DEV]) pick_id = ID_W'(NUM_DEV);
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign clr_v[g] = take && (pick_id == ID_W'(g));

        always_ff @(posedge clk) begin
            if (rst)            pend_q[g] <= 1'b0;
            else if (set_v[g])  pend_q[g] <= 1'b1;
            else if (clr_v[g])  pend_q[g] <= 1'b0;
        end

        // R11
        clr_only_pending_chk: assert property (@(posedge clk) disable iff (rst)
            clr_v[g] |-> pend_q[g]);
    end

    // R3
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_v));

endmodule

// File: rtl/irq_ctx_store.sv
module irq_ctx_store
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              save,
    input  logic              restore,
    input  logic              to_user,
    input  logic [ADDR_W-1:0] pc_in,
    output logic              mode,
    output logic [ADDR_W-1:0] saved_pc
);
    logic saved_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= MODE_MONITOR;
            saved_mode <= MODE_MONITOR;
            saved_pc   <= '0;
        end else if (save) begin
            saved_pc   <= pc_in;
            saved_mode <= mode;
            mode       <= MODE_MONITOR;
        end else if (restore) begin
            mode       <= saved_mode;
        end else if (to_user) begin
            mode       <= MODE_USER;
        end
    end

    // R7
    restore_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (restore && !save) |=> (mode == $past(saved_mode)));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int          NUM_DEV   = 8,
    parameter int          ADDR_W    = 32,
    parameter int unsigned VEC_BASE  = 0,
    parameter int unsigned PTR_BYTES = 4,
    parameter int          ID_W      = $clog2(NUM_DEV + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DEV-1:0] dev_req,
    input  logic               trap_req,
    input  logic               insn_done,
    input  logic [ADDR_W-1:0]  ret_pc,
    input  logic               rti_strobe,
    input  logic               enter_user,
    output logic               vec_valid,
    output logic [ADDR_W-1:0]  vec_addr,
    input  logic               vec_ready,
    input  logic               vec_rsp_valid,
    input  logic [ADDR_W-1:0]  vec_rsp_data,
    output logic               redirect_valid,
    output logic [ADDR_W-1:0]  redirect_pc,
    output logic [ID_W-1:0]    grant_id,
    output logic               priv_mode,
    output logic               in_service
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);

    seq_state_e        state_q;
    logic              take;
    logic              leave;
    logic              any_pend;
    logic [ID_W-1:0]   pick_id;
    logic [ADDR_W-1:0] saved_pc;
    logic [ADDR_W-1:0] slot_addr;

    assign take  = (state_q == SQ_IDLE) && insn_done && any_pend;
    assign leave = (state_q == SQ_SERVE) && rti_strobe;

    assign slot_addr = BASE_A + ADDR_W'(slot_offset(int'(pick_id), PTR_BYTES));

    irq_pend_latch #(.NUM_DEV(NUM_DEV), .ID_W(ID_W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .dev_req  (dev_req),
        .trap_req (trap_req),
        .take     (take),
        .any_pend (any_pend),
        .pick_id  (pick_id)
    );

    irq_ctx_store #(.ADDR_W(ADDR_W)) u_ctx (
        .clk      (clk),
        .rst      (rst),
        .save     (take),
        .restore  (leave),
        .to_user  (enter_user),
        .pc_in    (ret_pc),
        .mode     (priv_mode),
        .saved_pc (saved_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= SQ_IDLE;
            vec_addr       <= '0;
            grant_id       <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (take) begin
                        state_q  <= SQ_FETCH;
                        vec_addr <= slot_addr;
                        grant_id <= pick_id;
                    end
                end
                SQ_FETCH: begin
                    if (vec_ready) state_q <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (vec_rsp_valid) begin
                        state_q        <= SQ_SERVE;
                        redirect_valid <= 1'b1;
                        redirect_pc    <= vec_rsp_data;
                    end
                end
                SQ_SERVE: begin
                    if (leave) begin
                        state_q        <= SQ_IDLE;
                        redirect_valid <= 1'b1;
                        redirect_pc    <= saved_pc;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign vec_valid  = (state_q == SQ_FETCH);
    assign in_service = (state_q != SQ_IDLE);

    // R5
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr)));

    // R5
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> !redirect_valid);

    // R2
    entry_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_valid) |-> $past(insn_done));

    // R6
    monitor_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (priv_mode == MODE_MONITOR));

    // R8
    no_reentry_chk: assert property (@(posedge clk) disable iff (rst)
        (in_service && !rti_strobe) |=> !$rose(vec_valid));

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    localparam int NUM_DEV = 8;
    localparam int ADDR_W  = 32;
    localparam int ID_W    = 4;
    localparam int ROWS    = 8;

    // stimulus table: device mask, trap, return pc, go to user first, ready delay
    localparam logic [7:0]  T_MASK [ROWS] = '{8'h04, 8'h10, 8'h80, 8'h01, 8'h00, 8'h60, 8'h00, 8'h00};
    localparam logic        T_TRAP [ROWS] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [31:0] T_PC   [ROWS] = '{32'h100, 32'h204, 32'h308, 32'h40C,
                                              32'h510, 32'h614, 32'h718, 32'h81C};
    localparam logic        T_USER [ROWS] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam int          T_DLY  [ROWS] = '{0, 2, 1, 3, 0, 1, 0, 2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_DEV-1:0] dev_req = '0;
    logic trap_req = 1'b0, insn_done = 1'b0, rti_strobe = 1'b0, enter_user = 1'b0;
    logic [ADDR_W-1:0] ret_pc = '0;
    logic vec_valid, vec_ready = 1'b0, vec_rsp_valid = 1'b0;
    logic [ADDR_W-1:0] vec_addr, vec_rsp_data = '0, redirect_pc;
    logic redirect_valid, priv_mode, in_service;
    logic [ID_W-1:0] grant_id;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    logic [NUM_DEV:0] m_pend = '0;
    logic m_mode = 1'b0, m_saved_mode = 1'b0;
    logic [ADDR_W-1:0] m_saved_pc = '0;

    always #10 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst(rst), .dev_req(dev_req), .trap_req(trap_req),
        .insn_done(insn_done), .ret_pc(ret_pc), .rti_strobe(rti_strobe),
        .enter_user(enter_user), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .vec_ready(vec_ready), .vec_rsp_valid(vec_rsp_valid), .vec_rsp_data(vec_rsp_data),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .grant_id(grant_id),
        .priv_mode(priv_mode), .in_service(in_service)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int pick_model(input logic [NUM_DEV:0] p);
        if (p[NUM_DEV]) return NUM_DEV;
        for (int i = 0; i < NUM_DEV; i++) if (p[i]) return i;
        return 0;
    endfunction

    task automatic post(input logic [7:0] mask, input logic trap);
        @(negedge clk) dev_req = mask; trap_req = trap;
        @(negedge clk) dev_req = '0; trap_req = 1'b0;
        m_pend = m_pend | {trap, mask};
    endtask

    task automatic enter(input logic [7:0] mask, input logic trap, input logic [31:0] pc,
                         input logic user, input int dly);
        int id;
        logic [ADDR_W-1:0] ptr;
        if (mask != 0 || trap) post(mask, trap);
        if (user) begin
            enter_user = 1'b1;
            @(negedge clk) enter_user = 1'b0;
            m_mode = 1'b1;
            chk("R10 user mode", priv_mode, 1);
        end
        ret_pc = pc; insn_done = 1'b1;
        @(negedge clk) insn_done = 1'b0;
        id = pick_model(m_pend);
        m_pend[id] = 1'b0;
        m_saved_pc = pc; m_saved_mode = m_mode; m_mode = 1'b0;
        chk("R2 entry taken", vec_valid, 1);
        chk("R3 grant id", grant_id, id);
        chk("R4 slot address", vec_addr, id * 4);
        chk("R6 monitor at entry", priv_mode, 0);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk("R5 valid held", vec_valid, 1);
            chk("R5 address held", vec_addr, id * 4);
        end
        vec_ready = 1'b1;
        @(negedge clk) vec_ready = 1'b0;
        chk("R5 request dropped", vec_valid, 0);
        chk("R5 no early redirect", redirect_valid, 0);
        ptr = 32'h8000_0000 | (id << 4);
        vec_rsp_valid = 1'b1; vec_rsp_data = ptr;
        @(negedge clk) vec_rsp_valid = 1'b0;
        chk("R5 redirect pulse", redirect_valid, 1);
        chk("R5 redirect target", redirect_pc, ptr);
        @(negedge clk);
        chk("R5 pulse width", redirect_valid, 0);
    endtask

    task automatic leave();
        rti_strobe = 1'b1;
        @(negedge clk) rti_strobe = 1'b0;
        m_mode = m_saved_mode;
        chk("R7 return redirect", redirect_valid, 1);
        chk("R7 return pc", redirect_pc, m_saved_pc);
        chk("R7 mode restored", priv_mode, m_mode);
        chk("R7 service ended", in_service, 0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mode", priv_mode, 0);
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 redirect", redirect_valid, 0);
        chk("R1 in_service", in_service, 0);

        // R9: return strobe while idle
        enter_user = 1'b1;
        @(negedge clk) enter_user = 1'b0;
        m_mode = 1'b1;
        chk("R10 user mode", priv_mode, 1);
        rti_strobe = 1'b1;
        @(negedge clk) rti_strobe = 1'b0;
        chk("R9 no redirect", redirect_valid, 0);
        chk("R9 mode kept", priv_mode, 1);

        // R2: pending but no boundary strobe
        post(8'h08, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R2 waits for boundary", vec_valid, 0);
        end

        for (int r = 0; r < ROWS; r++) begin
            enter(T_MASK[r], T_TRAP[r], T_PC[r], T_USER[r], T_DLY[r]);
            leave();
        end

        // R8: requests during service are held
        enter(8'h02, 1'b0, 32'hA00, 1'b1, 0);
        dev_req = 8'h01; insn_done = 1'b1;
        @(negedge clk) dev_req = '0;
        m_pend[0] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            chk("R8 held during service", vec_valid, 0);
            chk("R8 still in service", in_service, 1);
            @(negedge clk);
        end
        insn_done = 1'b0;
        leave();
        enter(8'h00, 1'b0, 32'hB04, 1'b0, 1);
        leave();

        // R11: request and grant of the same source in one cycle stay pending
        post(8'h04, 1'b0);
        dev_req = 8'h04; ret_pc = 32'hC00; insn_done = 1'b1;
        @(negedge clk) dev_req = '0; insn_done = 1'b0;
        m_saved_pc = 32'hC00; m_saved_mode = m_mode; m_mode = 1'b0;
        chk("R11 first grant", grant_id, 2);
        vec_ready = 1'b1;
        @(negedge clk) vec_ready = 1'b0; vec_rsp_valid = 1'b1; vec_rsp_data = 32'h9000;
        @(negedge clk) vec_rsp_valid = 1'b0;
        @(negedge clk);
        leave();
        enter(8'h00, 1'b0, 32'hC10, 1'b0, 0);
        chk("R11 re-request kept", grant_id, 2);
        leave();

        while (m_pend != '0) begin
            enter(8'h00, 1'b0, 32'hD00, 1'b0, 0);
            leave();
        end

        finished = 1'b1;
        report();
    end
endmodule